// File: doc/BRIEF.md
# Circular Return-Address Stack

This block holds the return addresses of a small microcontroller core. A subroutine call or an interrupt vector pushes the current program-counter value. A return-type instruction pops it. Storage is a private array of eight 13-bit words that sits outside both program memory and data memory. The level pointer is internal and software has no path to read it or write it.

The array behaves as a ring. A push past the eighth level overwrites the oldest saved address. A pop past the bottom wraps around and returns whatever stale word the pointer lands on. No overflow or underflow flag exists.

The top entry is driven combinationally, so on the cycle a pop strobe is raised the core can load the program counter straight from `top_o`. Reset returns the pointer to level zero but does not clear the saved words.

Top module: `retaddr_stack`

## Requirements
- R1: While `rst_n` is low, the level pointer is zero. After reset, a push of address A makes `top_o` equal A on the following cycle.
- R2: A push (`push_i`=1, `pop_i`=0) stores `addr_i` at the next level. The new value appears on `top_o` from the next cycle.
- R3: In the cycle a pop (`pop_i`=1, `push_i`=0) is asserted, `top_o` shows the newest unpopped address. After the pop, the previous level becomes the top, so entries come back in last-in, first-out order.
- R4: The pointer wraps modulo 8 upward. After ten pushes v0..v9, eight pops return v9 down to v2. The first two pushes were overwritten, and no flag reports this.
- R5: The pointer wraps modulo 8 downward. Popping more times than was pushed returns the stale words the wrapped pointer selects, and no flag reports this.
- R6: When `push_i` and `pop_i` are both 1, `top_o` shows the old top in that cycle. The top word is replaced by `addr_i` and the depth does not change.
- R7: With neither strobe asserted, the pointer and `top_o` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears the pointer only |
| push_i | input | 1 | Save `addr_i` as the new top (call or interrupt) |
| pop_i | input | 1 | Discard the top (return instruction) |
| addr_i | input | 13 | Return address to save |
| top_o | output | 13 | Current top-of-stack word, combinational |

## Verification
The bench drives several patterns:
- Single push-pop pairs confirm reset and that the top appears one cycle after a push.
- Nested and interleaved call/return runs separate correct LIFO order from FIFO or off-by-one indexing.
- Ten pushes followed by ten pops check both wrap directions. Eight pops show that the two oldest entries were overwritten. The next two pops show that the pointer rolls below zero onto stale words rather than saturating.
- A simultaneous push and pop, followed by idle cycles, separates replace-in-place from a net push or pop. The idle cycles also expose any drift of the pointer or the top word.

// File: rtl/retstk_pkg.sv
package retstk_pkg;
    parameter int unsigned STK_DEPTH = 8;
    parameter int unsigned STK_AW    = 13;
    localparam int unsigned STK_PTR_W = (STK_DEPTH > 1) ? $clog2(STK_DEPTH) : 1;
endpackage

// File: rtl/retstk_ctrl.sv
module retstk_ctrl #(
    parameter int unsigned DEPTH = retstk_pkg::STK_DEPTH,
    parameter int unsigned PTR_W = retstk_pkg::STK_PTR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic [PTR_W-1:0] rd_idx_o,
    output logic [PTR_W-1:0] ptr_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ctrl_t;

    ctrl_t            st_d, st_q;
    logic [PTR_W-1:0] up_d, down_d;

    always_comb begin
        st_d   = st_q;
        up_d   = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
        down_d = (st_q.ptr == '0) ? LAST : st_q.ptr - 1'b1;
        unique case ({push_i, pop_i})
            2'b10:   st_d.ptr = up_d;
            2'b01:   st_d.ptr = down_d;
            default: st_d.ptr = st_q.ptr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // The top sits one level below the pointer; a push with pop rewrites it.
    assign rd_idx_o = down_d;
    assign wr_idx_o = pop_i ? down_d : st_q.ptr;
    assign wr_en_o  = push_i;
    assign ptr_o    = st_q.ptr;
endmodule

// File: rtl/retstk_regs.sv
module retstk_regs #(
    parameter int unsigned DEPTH = retstk_pkg::STK_DEPTH,
    parameter int unsigned AW    = retstk_pkg::STK_AW,
    parameter int unsigned PTR_W = retstk_pkg::STK_PTR_W
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_idx_i,
    input  logic [AW-1:0]    wr_data_i,
    input  logic [PTR_W-1:0] rd_idx_i,
    output logic [AW-1:0]    rd_data_o
);
    logic [AW-1:0] word_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_level
        logic [AW-1:0] cell_d, cell_q;

        always_comb begin
            cell_d = cell_q;
            if (wr_en_i && (wr_idx_i == PTR_W'(g))) cell_d = wr_data_i;
        end

        // No reset: saved words survive reset and start undefined.
        always_ff @(posedge clk) begin
            cell_q <= cell_d;
        end

        assign word_q[g] = cell_q;
    end

    assign rd_data_o = word_q[rd_idx_i];
endmodule

// File: rtl/retaddr_stack.sv
module retaddr_stack #(
    parameter int unsigned DEPTH = retstk_pkg::STK_DEPTH,
    parameter int unsigned AW    = retstk_pkg::STK_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] top_o
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             wr_en;
    logic [PTR_W-1:0] wr_idx, rd_idx, ptr_q;

    retstk_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push_i),
        .pop_i    (pop_i),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx),
        .rd_idx_o (rd_idx),
        .ptr_o    (ptr_q)
    );

    retstk_regs #(.DEPTH(DEPTH), .AW(AW), .PTR_W(PTR_W)) u_regs (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (addr_i),
        .rd_idx_i  (rd_idx),
        .rd_data_o (top_o)
    );
endmodule

// File: rtl/retstk_chk.sv
module retstk_chk #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned AW    = 13,
    parameter int unsigned PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_i,
    input logic             pop_i,
    input logic [AW-1:0]    addr_i,
    input logic [AW-1:0]    top_o,
    input logic [PTR_W-1:0] ptr_q
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_ptr: assert (ptr_q == '0)
                else $error("R1: pointer not zero in reset");
        end
    end

    a_r2_push_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=>
            (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));

    a_r2_push_top: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (top_o == $past(addr_i)));

    a_r3_pop_retreat: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=>
            (ptr_q == (($past(ptr_q) == '0) ? LAST : $past(ptr_q) - 1'b1)));

    a_r6_replace_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> $stable(ptr_q));

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> $stable(ptr_q));
endmodule

bind retaddr_stack retstk_chk #(.DEPTH(DEPTH), .AW(AW), .PTR_W(PTR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (push_i),
    .pop_i  (pop_i),
    .addr_i (addr_i),
    .top_o  (top_o),
    .ptr_q  (ptr_q)
);

// File: tb/sim_retaddr_stack.sv
`timescale 1ns/1ps
module sim_retaddr_stack;
    localparam int AW = 13;
    localparam int DEPTH = 8;

    typedef struct {
        logic [AW-1:0] exp;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0;
    logic          pop_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] top_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [AW-1:0] mdl [DEPTH];
    int            mp = 0;
    item_t         sbq [$];

    retaddr_stack u0 (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .addr_i(addr_i), .top_o(top_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares top_o at each pop against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && pop_i) begin
            if (sbq.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard: actual=pop expected=no pop");
            end else begin
                item_t it;
                it = sbq.pop_front();
                check(it.tag, top_o, it.exp);
            end
        end
    end

    task automatic cyc(input bit ps, input bit pp, input logic [AW-1:0] a, input string tag);
        @(posedge clk); #1;
        push_i = ps; pop_i = pp; addr_i = a;
        if (pp) begin
            item_t it;
            it.exp = mdl[(mp + DEPTH - 1) % DEPTH];
            it.tag = tag;
            sbq.push_back(it);
        end
        if (ps && pp)      mdl[(mp + DEPTH - 1) % DEPTH] = a;
        else if (ps)       begin mdl[mp] = a; mp = (mp + 1) % DEPTH; end
        else if (pp)       mp = (mp + DEPTH - 1) % DEPTH;
    endtask

    task automatic idle_check(input string tag);
        cyc(1'b0, 1'b0, '0, tag);
        @(negedge clk);
        check(tag, top_o, mdl[(mp + DEPTH - 1) % DEPTH]);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset then one push
        cyc(1'b1, 1'b0, 13'h0AB, "R1");
        idle_check("R1");
        cyc(1'b0, 1'b1, '0, "R1");

        // R2/R3: nested and interleaved calls
        cyc(1'b1, 1'b0, 13'h111, "R2");
        cyc(1'b1, 1'b0, 13'h222, "R2");
        idle_check("R2");
        cyc(1'b0, 1'b1, '0, "R3");
        cyc(1'b1, 1'b0, 13'h333, "R2");
        cyc(1'b0, 1'b1, '0, "R3");
        cyc(1'b0, 1'b1, '0, "R3");

        // R4/R5: ten pushes, ten pops
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 13'(13'h1000 + i * 13'h11), "R4");
        idle_check("R4");
        for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1, '0, "R4");
        for (int i = 0; i < 2; i++) cyc(1'b0, 1'b1, '0, "R5");
        // R5: keep popping past empty onto stale words
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, '0, "R5");

        // R6: simultaneous push and pop
        cyc(1'b1, 1'b0, 13'h0F0, "R6");
        cyc(1'b1, 1'b1, 13'h1E1, "R6");
        idle_check("R6");
        cyc(1'b0, 1'b1, '0, "R6");

        // R7: idle cycles hold the top
        for (int i = 0; i < 4; i++) idle_check("R7");
        cyc(1'b0, 1'b1, '0, "R7");

        cyc(1'b0, 1'b0, '0, "end");
        repeat (2) @(negedge clk);
        check("scoreboard", AW'(sbq.size()), '0);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule